// File: doc/BRIEF.md
# Clock Power-Down Gating Controller

This block sits between the synthesizer core of a clock generator and its output buffers. It decides when a group of single-ended clocks and one differential clock pair may toggle. It also decides when the crystal oscillator and the PLL may run. All of this is driven by a single shared input pad. After reset the pad is read as a power-good qualifier. Once it has been seen high, it becomes an active-low power-down request and keeps that role for good.

A power-down request is synchronized into the reference clock domain and accepted once it has been sampled low on two consecutive reference rising edges. Each output's enable is then resynchronized in that output's own clock domain. The enable changes only while that clock is low, so each output stops low without a truncated pulse. Only when every output has stopped, and a settle window has passed, does the block drop the oscillator and PLL enables.

Raising the pad wakes the block asynchronously, even with the reference clock stopped. The enables return at once. Each output reopens a fixed number of its own cycles after the PLL reports lock. If lock is lost while the outputs run, they close again, but the oscillator and PLL stay enabled.

Top module: `clk_pd_gate_ctrl`

## Requirements
- R1: While reset is asserted, every single-ended output, both sides of the differential pair, `osc_en`, `pll_en` and `all_running` are low.
- R2: Until the pad has been sampled high in the reference domain, holding it low keeps `osc_en` and `pll_en` low. Within 5 reference cycles of the pad going high, both enables are high. From then on a low pad only means a power-down request, and never again a power-good qualifier.
- R3: A power-down request is accepted only when the pad is low at two consecutive reference rising edges. A low pulse that covers a single rising edge changes neither the enables nor the running outputs.
- R4: After a request is accepted, every output stops at the end of a complete high phase and stays low. The true and complement sides of the differential pair both end low.
- R5: `osc_en` and `pll_en` fall only after every output is held low. No output toggles while the enables are low.
- R6: When the pad is raised, both enables return high. All outputs stay low until `pll_lock` is high.
- R7: With the open delay set to 4, each output's first rising edge after `pll_lock` rises comes on the 7th rising edge of its own source clock. That is 2 synchronizer edges, 4 counted edges and 1 edge through the gate. `all_running` is high once every output is open.
- R8: Raising the pad re-enables the oscillator and PLL with no reference clock edge at all.
- R9: Loss of `pll_lock` while the outputs run stops all outputs low while `osc_en` and `pll_en` stay high. When lock returns, the outputs reopen.
- R10: Every output high pulse, and every complement-side high pulse, lasts exactly half a period of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that samples the pad |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_n | input | 1 | Shared pad: power-good qualifier first, then active-low power-down request |
| se_src_clk | input | NUM_SE | Ungated single-ended source clocks |
| diff_src_clk | input | 1 | Ungated source clock of the differential pair |
| pll_lock | input | 1 | Lock report from the PLL |
| se_clk_out | output | NUM_SE | Gated single-ended clocks |
| diff_out_p | output | 1 | Gated differential true side |
| diff_out_n | output | 1 | Gated differential complement side |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| all_running | output | 1 | High when every output gate is open |

## Verification
The bench drives the pad low before power-good is seen, to show that this cannot start a shutdown. It then sends a low pulse that covers one reference edge and a held low that covers many, which separates a rejected request from an accepted one. A wake with the reference clock stopped tells an asynchronous release apart from a sampled one. A lock drop with the pad high tells the lock-loss path apart from power-down. Four source clocks with different periods show that each output counts its own edges on reopening and ends with a whole pulse when it closes.

// File: rtl/cpg_pkg.sv
`timescale 1ns/1ps
package cpg_pkg;
   typedef enum logic {GATE_SE = 1'b0, GATE_DIFF = 1'b1} gate_kind_e;

   function automatic int cnt_width(input int top);
      return (top < 2) ? 1 : $clog2(top + 1);
   endfunction
endpackage

// File: rtl/cpg_sync.sv
`timescale 1ns/1ps
module cpg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cpg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cpg_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cpg_gate.sv
`timescale 1ns/1ps
module cpg_gate
   import cpg_pkg::*;
#(
   parameter gate_kind_e KIND        = GATE_SE,
   parameter int         SYNC_STAGES = 2,
   parameter int         OPEN_DELAY  = 4
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic want,
   output logic out_p,
   output logic out_n,
   output logic opened,
   output logic closed
);
   localparam int            CW      = cnt_width(OPEN_DELAY);
   localparam logic [CW-1:0] CNT_TOP = CW'(OPEN_DELAY);

   if (OPEN_DELAY < 1) begin : g_bad_delay
      $error("cpg_gate: OPEN_DELAY must be at least 1");
   end

   logic          want_s;
   logic [CW-1:0] cnt;
   logic          ready;
   logic          en_q;

   // request resynchronized into this output's own clock
   cpg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_want_sync (
      .clk   (src_clk),
      .arst_n(rst_n),
      .d     (want),
      .q     (want_s)
   );

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!want_s)     cnt <= '0;
      else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
   end

   assign ready = (cnt == CNT_TOP);

   // enable moves only on the falling edge, so the AND below never chops a pulse
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= want_s & ready;
   end

   assign out_p = src_clk & en_q;

   if (KIND == GATE_DIFF) begin : g_diff
      logic en_c;
      // complement side is high while src_clk is low: retime its enable to the rising edge
      always_ff @(posedge src_clk or negedge rst_n) begin
         if (!rst_n) en_c <= 1'b0;
         else        en_c <= en_q;
      end
      assign out_n  = ~src_clk & en_c;
      assign opened = en_q & en_c;
      assign closed = ~en_q & ~en_c;
   end else begin : g_se
      assign out_n  = 1'b0;
      assign opened = en_q;
      assign closed = ~en_q;
   end
endmodule

// File: rtl/cpg_ref_ctrl.sv
`timescale 1ns/1ps
module cpg_ref_ctrl
   import cpg_pkg::*;
#(
   parameter int NUM_GATES     = 4,
   parameter int SYNC_STAGES   = 2,
   parameter int PD_CONFIRM    = 2,
   parameter int SETTLE_CYCLES = 16
) (
   input  logic                 ref_clk,
   input  logic                 rst_n,
   input  logic                 pad_n,
   input  logic                 pll_lock,
   input  logic [NUM_GATES-1:0] run_vec,
   input  logic [NUM_GATES-1:0] idle_vec,
   output logic                 mode_pd,
   output logic                 pd_active,
   output logic                 want,
   output logic                 osc_en,
   output logic                 pll_en,
   output logic                 all_running
);
   localparam int            SW      = cnt_width(SETTLE_CYCLES);
   localparam logic [SW-1:0] SET_TOP = SW'(SETTLE_CYCLES);

   if (SETTLE_CYCLES < PD_CONFIRM) begin : g_bad_settle
      $error("cpg_ref_ctrl: SETTLE_CYCLES must not be below PD_CONFIRM");
   end

   logic                   pg_s;
   logic                   pd_rel_n;
   logic [SW-1:0]          settle;
   logic [2*NUM_GATES-1:0] fb_s;
   logic [NUM_GATES-1:0]   run_s;
   logic [NUM_GATES-1:0]   idle_s;
   logic                   drained;
   logic                   en_int;

   // power-good phase: pad sampled through a plain synchronizer
   cpg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pg_sync (
      .clk   (ref_clk),
      .arst_n(rst_n),
      .d     (pad_n),
      .q     (pg_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)    mode_pd <= 1'b0;
      else if (pg_s) mode_pd <= 1'b1;
   end

   // request chain: a high pad clears it at once, a low pad must survive PD_CONFIRM edges
   assign pd_rel_n = rst_n & ~pad_n;

   cpg_sync #(.WIDTH(1), .STAGES(PD_CONFIRM)) u_pd_sync (
      .clk   (ref_clk),
      .arst_n(pd_rel_n),
      .d     (mode_pd),
      .q     (pd_active)
   );

   always_ff @(posedge ref_clk or negedge pd_rel_n) begin
      if (!pd_rel_n)                        settle <= '0;
      else if (pd_active && settle != SET_TOP) settle <= settle + 1'b1;
   end

   cpg_sync #(.WIDTH(2*NUM_GATES), .STAGES(SYNC_STAGES)) u_fb_sync (
      .clk   (ref_clk),
      .arst_n(rst_n),
      .d     ({run_vec, idle_vec}),
      .q     (fb_s)
   );

   assign run_s  = fb_s[2*NUM_GATES-1:NUM_GATES];
   assign idle_s = fb_s[NUM_GATES-1:0];

   assign drained     = pd_active & (settle == SET_TOP) & (&idle_s);
   assign en_int      = mode_pd & ~drained;
   assign osc_en      = en_int;
   assign pll_en      = en_int;
   assign want        = en_int & ~pd_active & pll_lock;
   assign all_running = &run_s;
endmodule

// File: rtl/clk_pd_gate_ctrl.sv
`timescale 1ns/1ps
module clk_pd_gate_ctrl
   import cpg_pkg::*;
#(
   parameter int NUM_SE        = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int PD_CONFIRM    = 2,
   parameter int OPEN_DELAY    = 4,
   parameter int SETTLE_CYCLES = 16
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              pad_n,
   input  logic [NUM_SE-1:0] se_src_clk,
   input  logic              diff_src_clk,
   input  logic              pll_lock,
   output logic [NUM_SE-1:0] se_clk_out,
   output logic              diff_out_p,
   output logic              diff_out_n,
   output logic              osc_en,
   output logic              pll_en,
   output logic              all_running
);
   localparam int NUM_GATES = NUM_SE + 1;

   if (NUM_SE < 1) begin : g_bad_num
      $error("clk_pd_gate_ctrl: NUM_SE must be at least 1");
   end

   logic [NUM_GATES-1:0] src_clk;
   logic [NUM_GATES-1:0] gate_p;
   logic [NUM_GATES-1:0] gate_n;
   logic [NUM_GATES-1:0] run_vec;
   logic [NUM_GATES-1:0] idle_vec;
   logic                 mode_pd;
   logic                 pd_active;
   logic                 want;
   logic                 unused_n;

   assign src_clk = {diff_src_clk, se_src_clk};

   cpg_ref_ctrl #(
      .NUM_GATES    (NUM_GATES),
      .SYNC_STAGES  (SYNC_STAGES),
      .PD_CONFIRM   (PD_CONFIRM),
      .SETTLE_CYCLES(SETTLE_CYCLES)
   ) u_ctrl (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .pad_n      (pad_n),
      .pll_lock   (pll_lock),
      .run_vec    (run_vec),
      .idle_vec   (idle_vec),
      .mode_pd    (mode_pd),
      .pd_active  (pd_active),
      .want       (want),
      .osc_en     (osc_en),
      .pll_en     (pll_en),
      .all_running(all_running)
   );

   for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
      cpg_gate #(
         .KIND       ((g == NUM_SE) ? GATE_DIFF : GATE_SE),
         .SYNC_STAGES(SYNC_STAGES),
         .OPEN_DELAY (OPEN_DELAY)
      ) u_gate (
         .src_clk(src_clk[g]),
         .rst_n  (rst_n),
         .want   (want),
         .out_p  (gate_p[g]),
         .out_n  (gate_n[g]),
         .opened (run_vec[g]),
         .closed (idle_vec[g])
      );
   end

   assign se_clk_out = gate_p[NUM_SE-1:0];
   assign diff_out_p = gate_p[NUM_SE];
   assign diff_out_n = gate_n[NUM_SE];
   assign unused_n   = ^gate_n[NUM_SE-1:0];
endmodule

// File: rtl/clk_pd_gate_ctrl_chk.sv
`timescale 1ns/1ps
module clk_pd_gate_ctrl_chk #(
   parameter int NUM_SE = 3
) (
   input logic              ref_clk,
   input logic              rst_n,
   input logic              pad_n,
   input logic              pll_lock,
   input logic [NUM_SE-1:0] se_clk_out,
   input logic              diff_out_p,
   input logic              diff_out_n,
   input logic              osc_en,
   input logic              pll_en,
   input logic              all_running,
   input logic              mode_pd,
   input logic              pd_active
);
   // R1: quiet outputs under reset
   always @(posedge ref_clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (se_clk_out == '0 && !diff_out_p && !diff_out_n
                                   && !osc_en && !pll_en && !all_running)
            else $error("a_r1_reset_quiet");
      end
   end

   a_r2_enable_needs_pg: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(pll_en) |-> mode_pd) else $error("a_r2_enable_needs_pg");

   a_r2_mode_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
      mode_pd |=> mode_pd) else $error("a_r2_mode_sticky");

   a_r3_two_low_samples: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(pll_en) |-> (!pad_n && $past(!pad_n))) else $error("a_r3_two_low_samples");

   a_r5_quiet_before_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(osc_en) |-> (se_clk_out == '0 && !diff_out_p && !diff_out_n))
      else $error("a_r5_quiet_before_off");

   a_r6_running_needs_pll: assert property (@(posedge ref_clk) disable iff (!rst_n)
      all_running |-> (pll_en && osc_en)) else $error("a_r6_running_needs_pll");

   a_r9_lockloss_keeps_en: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (mode_pd && !pd_active && $fell(pll_lock)) |-> pll_en)
      else $error("a_r9_lockloss_keeps_en");
endmodule

bind clk_pd_gate_ctrl clk_pd_gate_ctrl_chk #(.NUM_SE(NUM_SE)) u_chk (
   .ref_clk    (ref_clk),
   .rst_n      (rst_n),
   .pad_n      (pad_n),
   .pll_lock   (pll_lock),
   .se_clk_out (se_clk_out),
   .diff_out_p (diff_out_p),
   .diff_out_n (diff_out_n),
   .osc_en     (osc_en),
   .pll_en     (pll_en),
   .all_running(all_running),
   .mode_pd    (mode_pd),
   .pd_active  (pd_active)
);

// File: tb/tb_clk_pd_gate_ctrl.sv
`timescale 1ns/1ps
module tb_clk_pd_gate_ctrl;
   localparam int NUM_SE = 3;
   localparam int NG     = NUM_SE + 1;
   localparam int EXP_FIRST = 2 + 4 + 1;

   logic              ref_clk = 1'b0;
   logic              ref_run = 1'b1;
   logic              rst_n   = 1'b0;
   logic              pad_n   = 1'b0;
   logic              pll_lock = 1'b0;
   logic [NG-1:0]     src_clk = '0;
   logic [NUM_SE-1:0] se_out;
   logic              diff_p, diff_n, osc_en, pll_en, all_running;
   logic [NG-1:0]     obs_p;

   int checks = 0;
   int fails  = 0;

   clk_pd_gate_ctrl #(.NUM_SE(NUM_SE)) dut (
      .ref_clk     (ref_clk),
      .rst_n       (rst_n),
      .pad_n       (pad_n),
      .se_src_clk  (src_clk[NUM_SE-1:0]),
      .diff_src_clk(src_clk[NUM_SE]),
      .pll_lock    (pll_lock),
      .se_clk_out  (se_out),
      .diff_out_p  (diff_p),
      .diff_out_n  (diff_n),
      .osc_en      (osc_en),
      .pll_en      (pll_en),
      .all_running (all_running)
   );

   assign obs_p = {diff_p, se_out};

   // 200 MHz reference, stoppable
   initial forever begin
      #2.5;
      ref_clk = ref_run ? ~ref_clk : 1'b0;
   end

   // source clocks: half periods 4,5,6 ns for single-ended, 3 ns for the pair
   for (genvar g = 0; g < NG; g++) begin : g_src
      localparam real HALF = (g == NUM_SE) ? 3.0 : 4.0 + g;
      initial forever begin
         #(HALF);
         src_clk[g] = ~src_clk[g];
      end
   end

   int  src_edges [NG];
   int  out_edges [NG];
   real rise_t    [NG];
   int  glitch    [NG];
   int  first_cap [NG] = '{default: -1};
   int  base      [NG];
   int  snap      [NG];
   bit  arm = 1'b0;

   for (genvar g = 0; g < NG; g++) begin : g_mon
      localparam real HALF = (g == NUM_SE) ? 3.0 : 4.0 + g;
      always @(posedge src_clk[g]) src_edges[g]++;
      always @(posedge obs_p[g]) begin
         rise_t[g] = $realtime;
         out_edges[g]++;
         if (arm && first_cap[g] < 0) begin
            #0.1;
            first_cap[g] = src_edges[g] - base[g];
         end
      end
      always @(negedge obs_p[g]) begin
         if (rst_n && out_edges[g] > 0) begin
            if ($realtime - rise_t[g] < HALF - 0.01 || $realtime - rise_t[g] > HALF + 0.01)
               glitch[g]++;
         end
      end
   end

   real n_rise_t;
   int  n_edges = 0;
   int  n_glitch = 0;
   always @(posedge diff_n) begin
      n_rise_t = $realtime;
      n_edges++;
   end
   always @(negedge diff_n) begin
      if (rst_n && n_edges > 0) begin
         if ($realtime - n_rise_t < 2.99 || $realtime - n_rise_t > 3.01) n_glitch++;
      end
   end

   int r5_viol = 0;
   always @(obs_p or diff_n) begin
      if (rst_n && !pll_en && !osc_en) r5_viol++;
   end

   int run_falls = 0;
   always @(negedge all_running) begin
      if (rst_n) run_falls++;
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge ref_clk);
      #0.3;
   endtask

   task automatic take_snap();
      for (int g = 0; g < NG; g++) snap[g] = out_edges[g];
   endtask

   task automatic check_frozen(input string tag);
      for (int g = 0; g < NG; g++)
         check(out_edges[g] == snap[g], tag, $sformatf("output %0d edges frozen", g),
               out_edges[g], snap[g]);
      check(obs_p == '0, tag, "true outputs low", obs_p, 0);
      check(diff_n == 1'b0, tag, "complement low", diff_n, 0);
   endtask

   task automatic run_seq();
      int e0;
      // R1: reset state
      step(10);
      check(obs_p == '0, "R1", "outputs in reset", obs_p, 0);
      check(diff_n == 1'b0, "R1", "complement in reset", diff_n, 0);
      check(osc_en == 1'b0 && pll_en == 1'b0, "R1", "enables in reset", {osc_en, pll_en}, 0);
      check(all_running == 1'b0, "R1", "running in reset", all_running, 0);

      // R2: low pad before power-good does nothing
      rst_n = 1'b1;
      step(20);
      check(pll_en == 1'b0 && osc_en == 1'b0, "R2", "enables with pad low in pg wait",
            {osc_en, pll_en}, 0);
      pad_n = 1'b1;
      step(5);
      check(pll_en == 1'b1 && osc_en == 1'b1, "R2", "enables after pg high",
            {osc_en, pll_en}, 3);

      // R6: no lock, no outputs
      take_snap();
      step(30);
      check_frozen("R6");
      check(all_running == 1'b0, "R6", "running before lock", all_running, 0);

      // R7: open delay counted per output clock
      for (int g = 0; g < NG; g++) base[g] = src_edges[g];
      arm = 1'b1;
      pll_lock = 1'b1;
      step(60);
      arm = 1'b0;
      for (int g = 0; g < NG; g++)
         check(first_cap[g] == EXP_FIRST, "R7", $sformatf("first edge index output %0d", g),
               first_cap[g], EXP_FIRST);
      check(all_running == 1'b1, "R7", "running after open", all_running, 1);

      // R3: low pulse covering one reference edge is ignored
      e0 = out_edges[0];
      pad_n = 1'b0;
      #4;
      pad_n = 1'b1;
      step(10);
      check(pll_en == 1'b1 && osc_en == 1'b1, "R3", "enables after short pulse",
            {osc_en, pll_en}, 3);
      check(run_falls == 0, "R3", "running drops after short pulse", run_falls, 0);
      check(out_edges[0] > e0 + 3, "R3", "output 0 still toggling", out_edges[0] - e0, 4);

      // R4 and R5: held request shuts down in order
      pad_n = 1'b0;
      step(80);
      check(pll_en == 1'b0 && osc_en == 1'b0, "R5", "enables after request", {osc_en, pll_en}, 0);
      check(all_running == 1'b0, "R4", "running after request", all_running, 0);
      pll_lock = 1'b0;
      take_snap();
      #100;
      check_frozen("R4");
      check(r5_viol == 0, "R5", "toggles with enables low", r5_viol, 0);

      // R8: wake with the reference stopped
      ref_run = 1'b0;
      #50;
      pad_n = 1'b1;
      #1;
      check(pll_en == 1'b1 && osc_en == 1'b1, "R8", "enables with reference stopped",
            {osc_en, pll_en}, 3);
      take_snap();
      #100;
      check_frozen("R6");
      ref_run = 1'b1;
      step(4);
      check(all_running == 1'b0, "R6", "running before relock", all_running, 0);
      pll_lock = 1'b1;
      step(60);
      check(all_running == 1'b1, "R6", "running after relock", all_running, 1);

      // R9: lock loss closes outputs, keeps enables
      pll_lock = 1'b0;
      step(20);
      take_snap();
      step(20);
      check_frozen("R9");
      check(pll_en == 1'b1 && osc_en == 1'b1, "R9", "enables on lock loss", {osc_en, pll_en}, 3);
      check(all_running == 1'b0, "R9", "running on lock loss", all_running, 0);
      pll_lock = 1'b1;
      step(60);
      check(all_running == 1'b1, "R9", "running after lock back", all_running, 1);

      // R10: whole pulses only
      for (int g = 0; g < NG; g++)
         check(glitch[g] == 0, "R10", $sformatf("short pulses output %0d", g), glitch[g], 0);
      check(n_glitch == 0, "R10", "short complement pulses", n_glitch, 0);
      check(n_edges > 10, "R10", "complement toggled", n_edges, 11);
   endtask

   initial begin
      fork
         run_seq();
         begin
            #100000;
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule